// File: doc/BRIEF.md
# Calendar Real-Time-Clock Register Block

This block is the bus-facing register file of a calendar clock. It keeps a packed date word, a packed time-of-day word, a control/status word and a bank of scratch words. All of them are reached through a 1 KiB window on a simple 32-bit bus that only accepts whole, aligned words. A one-pulse-per-second tick input moves the time of day forward. When the hour wraps, the tick also advances the weekday and bumps the day-of-month field.

Firmware sets the calendar by writing the date word or the time word. Each such write leaves a sticky marker in the control word. Reading the control word returns the markers and clears them, so software can confirm that its update landed. A build-time parameter selects one of two offset layouts. Both layouts decode onto the same set of registers; they differ in where the date and time words sit and in how many scratch words exist.

Top module: `rtc_regblock`

## Requirements
- R1: After a synchronous active-low reset, every implemented register reads as zero.
- R2: With LAYOUT=0, control is at 0x000, date at 0x004, time at 0x008, and scratch words 0..3 are at 0x020..0x02C. With LAYOUT=1, control is at 0x000, date at 0x010, time at 0x014, and scratch words 0..7 are at 0x100..0x11C.
- R3: A write to the date word stores all 32 bits and sets control bit 7. A write to the time word stores all 32 bits and sets control bit 8. The date word holds the year offset in bits 31:16, the month in bits 15:8 and the day in bits 7:0.
- R4: A read of the control word returns its value (bit 7 date marker, bit 8 time marker, all other bits zero) and clears both markers in that access. Bus writes to the control word have no effect.
- R5: An offset that maps to no register in the selected layout, or whose bits 1:0 are not zero, reads as zero and ignores writes.
- R6: The time word holds the weekday in bits 31:29, the hour in bits 23:16, the minute in bits 15:8 and the second in bits 7:0. On a tick the second field increments; 59 wraps to 0 and carries into the minute field, whose 59 wraps to 0 and carries into the hour field.
- R7: When a tick wraps the hour from 23 to 0, the weekday advances with 6 (Sunday) wrapping to 0 (Monday), and the date's day field increments by one.
- R8: A bus write to the time or date word in the same cycle as a tick stores the written value, and the tick has no effect on that word.
- R9: Read data appears on bus_rdata on the clock edge that samples the read strobe and holds until the next read.
- R10: Scratch words are plain read/write storage, independent of one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset inside the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |

## Verification
The hardest situation to reach is a full carry chain: one tick that wraps the seconds, minutes and hours, rolls the weekday from Sunday to Monday and bumps the day of month. Waiting for this through real ticks would take a simulated day. The bench instead preloads the time word with 23:59:59 on day 6 and the date word with a known day, then gives a single tick. The same preloading sets up the write-versus-tick collision: a time write is issued in the cycle the tick is high. A second instance built with the other layout shows that the same register set decodes at the alternate offsets.

// File: rtl/rtc_pkg.sv
// Shared definitions for the calendar clock register block.
// Assumes a 32-bit data path and the field positions listed here.
package rtc_pkg;
    localparam int DATA_W        = 32;
    localparam int DATE_FLAG_BIT = 7;
    localparam int TIME_FLAG_BIT = 8;

    typedef enum logic [2:0] {
        REG_NONE,
        REG_CTRL,
        REG_DATE,
        REG_TIME,
        REG_GP
    } reg_sel_e;
endpackage

// File: rtl/rtc_addr_decode.sv
// Address decoder: maps a byte offset to a register selector for one of two
// layouts. Assumes ADDR_W covers the 1 KiB window; misaligned offsets decode
// to nothing.
module rtc_addr_decode
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LAYOUT = 0,
    parameter int NUM_GP = 4,
    parameter int GP_IW  = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic [GP_IW-1:0]  gp_idx
);
    localparam int WW = ADDR_W - 2;
    localparam logic [WW-1:0] W_CTRL   = WW'(0);
    localparam logic [WW-1:0] W_DATE   = (LAYOUT == 0) ? WW'(1) : WW'(4);
    localparam logic [WW-1:0] W_TIME   = (LAYOUT == 0) ? WW'(2) : WW'(5);
    localparam logic [WW-1:0] W_GP0    = (LAYOUT == 0) ? WW'(8) : WW'(64);
    localparam logic [WW-1:0] W_GP_END = W_GP0 + WW'(NUM_GP);

    logic [WW-1:0] word;
    logic [WW-1:0] gp_off;
    assign word   = addr[ADDR_W-1:2];
    assign gp_off = word - W_GP0;

    // Pick the register selected by an aligned word offset.
    always_comb begin
        sel    = REG_NONE;
        gp_idx = '0;
        if (addr[1:0] == 2'b00) begin
            if (word == W_CTRL)      sel = REG_CTRL;
            else if (word == W_DATE) sel = REG_DATE;
            else if (word == W_TIME) sel = REG_TIME;
            else if (word >= W_GP0 && word < W_GP_END) begin
                sel    = REG_GP;
                gp_idx = GP_IW'(gp_off);
            end
        end
    end
endmodule

// File: rtl/rtc_clock_core.sv
// Time and date storage with the one-second advance. Bus writes take
// priority over the tick. Assumes tick is a single-cycle pulse.
module rtc_clock_core
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_date,
    input  logic              wr_time,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] date_q,
    output logic [DATA_W-1:0] time_q
);
    localparam logic [7:0] SEC_MAX  = 8'd59;
    localparam logic [7:0] MIN_MAX  = 8'd59;
    localparam logic [7:0] HOUR_MAX = 8'd23;
    localparam logic [2:0] DOW_MAX  = 3'd6;

    logic [7:0] sec, mins, hour, day;
    logic [2:0] dow;
    logic       sec_wrap, min_wrap, hour_wrap;
    logic [DATA_W-1:0] time_next, date_next;

    assign sec  = time_q[7:0];
    assign mins = time_q[15:8];
    assign hour = time_q[23:16];
    assign dow  = time_q[31:29];
    assign day  = date_q[7:0];

    // Carry chain from seconds up to the day field.
    always_comb begin
        sec_wrap  = (sec >= SEC_MAX);
        min_wrap  = sec_wrap && (mins >= MIN_MAX);
        hour_wrap = min_wrap && (hour >= HOUR_MAX);
        time_next = time_q;
        date_next = date_q;
        time_next[7:0] = sec_wrap ? 8'd0 : sec + 8'd1;
        if (sec_wrap)  time_next[15:8]  = (mins >= MIN_MAX) ? 8'd0 : mins + 8'd1;
        if (min_wrap)  time_next[23:16] = (hour >= HOUR_MAX) ? 8'd0 : hour + 8'd1;
        if (hour_wrap) begin
            time_next[31:29] = (dow >= DOW_MAX) ? 3'd0 : dow + 3'd1;
            date_next[7:0]   = day + 8'd1;
        end
    end

    // Time word: bus write wins, else tick advance.
    always_ff @(posedge clk) begin
        if (!rst_n)       time_q <= '0;
        else if (wr_time) time_q <= wdata;
        else if (tick)    time_q <= time_next;
    end

    // Date word: bus write wins, else day bump on hour wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)       date_q <= '0;
        else if (wr_date) date_q <= wdata;
        else if (tick)    date_q <= date_next;
    end

    p_sec_roll_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_time && time_q[7:0] == 8'd59) |=> time_q[7:0] == 8'd0);
    p_min_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_time && time_q[7:0] == 8'd59 && time_q[15:8] < 8'd59)
        |=> time_q[15:8] == $past(time_q[15:8]) + 8'd1);
    p_dow_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_time && time_q[23:0] == 24'h173B3B && time_q[31:29] == 3'd6)
        |=> time_q[31:29] == 3'd0);
    p_write_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_time |=> time_q == $past(wdata));
    p_date_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_date |=> date_q == $past(wdata));
endmodule

// File: rtl/rtc_scratch_bank.sv
// General-purpose scratch words: plain read/write storage with a
// combinational read mux. Assumes idx is below NUM_REGS when wr_en is high.
module rtc_scratch_bank #(
    parameter int NUM_REGS = 4,
    parameter int DATA_W   = 32,
    parameter int IDX_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_val
);
    logic [DATA_W-1:0] mem [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
        // One scratch word, loaded when addressed by a write.
        always_ff @(posedge clk) begin
            if (!rst_n)                              mem[i] <= '0;
            else if (wr_en && idx == IDX_W'(i))      mem[i] <= wdata;
        end

        p_store_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && idx == IDX_W'(i)) |=> mem[i] == $past(wdata));
    end

    // Select the addressed word for reading.
    always_comb begin
        rd_val = '0;
        for (int i = 0; i < NUM_REGS; i++)
            if (idx == IDX_W'(i)) rd_val = mem[i];
    end
endmodule

// File: rtl/rtc_regblock.sv
// Top of the calendar clock register block: decodes bus accesses, keeps the
// sticky update markers, and registers read data. Assumes single-cycle
// accesses and a one-cycle tick pulse.
module rtc_regblock
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LAYOUT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);
    localparam int NUM_GP = (LAYOUT == 0) ? 4 : 8;
    localparam int GP_IW  = $clog2(NUM_GP);

    reg_sel_e          sel;
    logic [GP_IW-1:0]  gp_idx;
    logic              wr_en, rd_en, wr_date, wr_time, wr_gp, rd_ctrl;
    logic              date_flag, time_flag;
    logic [DATA_W-1:0] date_q, time_q, gp_rd, ctrl_word, rd_next;

    rtc_addr_decode #(
        .ADDR_W(ADDR_W), .LAYOUT(LAYOUT), .NUM_GP(NUM_GP), .GP_IW(GP_IW)
    ) u_dec (
        .addr(bus_addr), .sel(sel), .gp_idx(gp_idx)
    );

    assign wr_en   = bus_sel && bus_wr;
    assign rd_en   = bus_sel && !bus_wr;
    assign wr_date = wr_en && sel == REG_DATE;
    assign wr_time = wr_en && sel == REG_TIME;
    assign wr_gp   = wr_en && sel == REG_GP;
    assign rd_ctrl = rd_en && sel == REG_CTRL;

    rtc_clock_core u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick_1hz),
        .wr_date(wr_date), .wr_time(wr_time), .wdata(bus_wdata),
        .date_q(date_q), .time_q(time_q)
    );

    rtc_scratch_bank #(
        .NUM_REGS(NUM_GP), .DATA_W(DATA_W), .IDX_W(GP_IW)
    ) u_gp (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_gp), .idx(gp_idx),
        .wdata(bus_wdata), .rd_val(gp_rd)
    );

    // Sticky update markers: set by date/time writes, cleared by a control read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            date_flag <= 1'b0;
            time_flag <= 1'b0;
        end else if (rd_ctrl) begin
            date_flag <= 1'b0;
            time_flag <= 1'b0;
        end else begin
            if (wr_date) date_flag <= 1'b1;
            if (wr_time) time_flag <= 1'b1;
        end
    end

    // Assemble the control word from the markers.
    always_comb begin
        ctrl_word = '0;
        ctrl_word[DATE_FLAG_BIT] = date_flag;
        ctrl_word[TIME_FLAG_BIT] = time_flag;
    end

    // Read mux over the decoded register.
    always_comb begin
        case (sel)
            REG_CTRL: rd_next = ctrl_word;
            REG_DATE: rd_next = date_q;
            REG_TIME: rd_next = time_q;
            REG_GP:   rd_next = gp_rd;
            default:  rd_next = '0;
        endcase
    end

    // Registered read data, updated only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     bus_rdata <= '0;
        else if (rd_en) bus_rdata <= rd_next;
    end

    p_date_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_date |=> date_flag);
    p_time_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_time |=> time_flag);
    p_ctrl_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ctrl |=> (!date_flag && !time_flag));
    p_unmapped_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == REG_NONE) |=> bus_rdata == 32'd0);
    p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(bus_rdata));
endmodule

// File: tb/sim_rtc_regblock.sv
module sim_rtc_regblock;
    localparam time CLK_PERIOD = 10ns;
    localparam int  NVEC = 21;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        sel = 1'b0;
    logic        wr = 1'b0;
    logic [9:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata_a, rdata_b;
    int          total = 0;
    int          bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rtc_regblock #(.ADDR_W(10), .LAYOUT(0)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick), .bus_sel(sel), .bus_wr(wr),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata_a)
    );
    rtc_regblock #(.ADDR_W(10), .LAYOUT(1)) u1 (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick), .bus_sel(sel), .bus_wr(wr),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata_b)
    );

    // {write, addr[9:0], wdata, expected read}
    localparam logic [74:0] VEC [NVEC] = '{
        {1'b1, 10'h020, 32'hA5A50001, 32'h0},        // R10
        {1'b0, 10'h020, 32'h0, 32'hA5A50001},        // R10 R2
        {1'b1, 10'h02C, 32'h0000BEEF, 32'h0},        // R10
        {1'b0, 10'h02C, 32'h0, 32'h0000BEEF},        // R10 R2
        {1'b1, 10'h004, 32'h00140C1F, 32'h0},        // R3
        {1'b0, 10'h004, 32'h0, 32'h00140C1F},        // R3
        {1'b0, 10'h000, 32'h0, 32'h00000080},        // R3 date marker
        {1'b0, 10'h000, 32'h0, 32'h00000000},        // R4 cleared
        {1'b1, 10'h008, 32'h00010203, 32'h0},        // R3
        {1'b0, 10'h000, 32'h0, 32'h00000100},        // R3 time marker
        {1'b0, 10'h008, 32'h0, 32'h00010203},        // R3 R2
        {1'b1, 10'h000, 32'hFFFFFFFF, 32'h0},        // R4 write ignored
        {1'b0, 10'h000, 32'h0, 32'h00000000},        // R4
        {1'b1, 10'h030, 32'h12345678, 32'h0},        // R5
        {1'b0, 10'h030, 32'h0, 32'h00000000},        // R5
        {1'b0, 10'h022, 32'h0, 32'h00000000},        // R5 misaligned read
        {1'b1, 10'h023, 32'hDEADBEEF, 32'h0},        // R5 misaligned write
        {1'b0, 10'h020, 32'h0, 32'hA5A50001},        // R5 unchanged
        {1'b0, 10'h010, 32'h0, 32'h00000000},        // R2 not date in layout 0
        {1'b1, 10'h100, 32'h11111111, 32'h0},        // R2 R5
        {1'b0, 10'h100, 32'h0, 32'h00000000}         // R2 R5
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic bus_write(input logic [9:0] a, input logic [31:0] d, input logic t);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d; tick = t;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0; tick = 1'b0;
    endtask

    // R9: data registered at the edge that samples the strobe, read after it.
    task automatic bus_read(input logic [9:0] a, output logic [31:0] da, output logic [31:0] db);
        sel = 1'b1; wr = 1'b0; addr = a;
        @(negedge clk);
        da = rdata_a; db = rdata_b;
        sel = 1'b0;
    endtask

    task automatic pulse_tick();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        total++; bad++;
        $display("FAIL watchdog: got %0d expected 0 timeouts", 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] ra, rb, hold;
        @(negedge clk);
        do_reset();

        // R1: reset state of layout 0 registers
        foreach (VEC[k]) begin end
        bus_read(10'h000, ra, rb); check("R1 ctrl", ra, 32'h0);
        bus_read(10'h004, ra, rb); check("R1 date", ra, 32'h0);
        bus_read(10'h008, ra, rb); check("R1 time", ra, 32'h0);
        bus_read(10'h024, ra, rb); check("R1 gp1", ra, 32'h0);

        // Vector table on layout 0
        for (int k = 0; k < NVEC; k++) begin
            if (VEC[k][74]) bus_write(VEC[k][73:64], VEC[k][63:32], 1'b0);
            else begin
                bus_read(VEC[k][73:64], ra, rb);
                check($sformatf("vector %0d", k), ra, VEC[k][31:0]);
            end
        end

        // R9: read data holds with no strobe
        hold = rdata_a;
        repeat (2) @(negedge clk);
        check("R9 hold", rdata_a, hold);

        // R6: plain second increment
        bus_write(10'h008, 32'h00010203, 1'b0);
        pulse_tick();
        bus_read(10'h008, ra, rb); check("R6 sec inc", ra, 32'h00010204);
        // R6: second wrap carries into minute
        bus_write(10'h008, 32'h0001023B, 1'b0);
        pulse_tick();
        bus_read(10'h008, ra, rb); check("R6 sec wrap", ra, 32'h00010300);
        // R6: minute wrap carries into hour
        bus_write(10'h008, 32'h00013B3B, 1'b0);
        pulse_tick();
        bus_read(10'h008, ra, rb); check("R6 min wrap", ra, 32'h00020000);

        // R7: full wrap, Sunday to Monday, day bump
        bus_write(10'h004, 32'h00140C1F, 1'b0);
        bus_write(10'h008, 32'hC0173B3B, 1'b0);
        pulse_tick();
        bus_read(10'h008, ra, rb); check("R7 time wrap", ra, 32'h00000000);
        bus_read(10'h004, ra, rb); check("R7 day bump", ra, 32'h00140C20);
        // R7: weekday 2 -> 3
        bus_write(10'h008, 32'h40173B3B, 1'b0);
        pulse_tick();
        bus_read(10'h008, ra, rb); check("R7 dow inc", ra, 32'h60000000);
        bus_read(10'h004, ra, rb); check("R7 day bump 2", ra, 32'h00140C21);

        // R8: write in tick cycle wins
        bus_write(10'h008, 32'h00050505, 1'b1);
        bus_read(10'h008, ra, rb); check("R8 time write wins", ra, 32'h00050505);
        bus_write(10'h008, 32'h00173B3B, 1'b0);
        bus_write(10'h004, 32'h00010101, 1'b1);
        bus_read(10'h004, ra, rb); check("R8 date write wins", ra, 32'h00010101);

        // R1: reset clears previously written state
        do_reset();
        bus_read(10'h004, ra, rb); check("R1 date after reset", ra, 32'h0);
        bus_read(10'h020, ra, rb); check("R1 gp0 after reset", ra, 32'h0);
        bus_read(10'h000, ra, rb); check("R1 ctrl after reset", ra, 32'h0);

        // R2: alternate layout on u1
        bus_write(10'h010, 32'h00350304, 1'b0);
        bus_read(10'h010, ra, rb); check("R2 layout1 date", rb, 32'h00350304);
        bus_read(10'h000, ra, rb); check("R3 layout1 marker", rb, 32'h00000080);
        bus_write(10'h014, 32'h200A0B0C, 1'b0);
        bus_read(10'h014, ra, rb); check("R2 layout1 time", rb, 32'h200A0B0C);
        bus_write(10'h11C, 32'h00000077, 1'b0);
        bus_read(10'h11C, ra, rb); check("R2 R10 layout1 gp7", rb, 32'h00000077);
        bus_read(10'h100, ra, rb); check("R10 layout1 gp0 untouched", rb, 32'h0);
        bus_read(10'h004, ra, rb); check("R5 layout1 hole", rb, 32'h0);
        bus_read(10'h020, ra, rb); check("R5 layout1 hole 2", rb, 32'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule